// File: doc/BRIEF.md
# Register-Mapped Parallel Link Bus Host

This block is the host end of a byte-wide parallel link that behaves like a small microprocessor bus to a peripheral. On the CPU side it presents eight byte-wide register offsets. Offsets 0 to 2 are local registers: a holding register, a read-only status register and a control register. Accessing offset 3 runs one address cycle on the link. Accessing any of offsets 4 to 7 runs one data cycle. A write runs a write cycle and a read runs a read cycle. Each link cycle is fully interlocked with the peripheral's active-low hold line: the strobe goes low, the peripheral raises hold to acknowledge, the strobe is released, and the cycle ends when hold falls again.

The CPU side is a single valid/ready channel. The requester raises `req_valid` with `req_write`, `req_offset` and `req_wdata`, and keeps all of them stable until `req_ready` is high at a rising clock edge. That edge is the handshake, and `req_rdata` is valid during the same cycle. Local offsets are granted in the cycle they are presented. Link offsets hold `req_ready` low until the link cycle has finished or has been aborted. This is the only back-pressure. Nothing is queued, so the requester has at most one access in flight.

A link cycle that receives no response within `TIMEOUT_CYCLES` clocks, in either wait phase, is aborted. The strobe is released and a sticky timeout flag is set. The peripheral interrupt line is watched for rising edges, which set a sticky pending flag that can drive `irq_o`.

Top module: `pbus_host`

## Requirements
- R1: After reset both strobes and `lnk_wr_n` are high, `lnk_ad_oe` is low, `irq_o` is low, and the holding and control registers read 0.
- R2: Offsets 0 (holding) and 2 (control) are read/write and grant `req_ready` in the cycle they are presented. After a link cycle completes without timeout, offset 0 holds the byte that cycle moved.
- R3: Offset 1 (status) is read-only and has this layout: bit 0 is the timeout flag, bit 1 is interrupt pending, bit 2 is the synchronized hold level, bit 3 is the synchronized interrupt line level, and bits 7:4 read 0. Writes to it change nothing.
- R4: In a write cycle `lnk_wr_n` falls first. `lnk_ad_oe` rises with the byte on `lnk_ad_out` one cycle later. The strobe falls one cycle after that. `lnk_ad_oe` stays high until the strobe has been released.
- R5: In a read cycle `lnk_wr_n` stays high and `lnk_ad_oe` stays low. The byte on `lnk_ad_in` is captured when hold is seen high and is returned in `req_rdata`.
- R6: Offset 3 drives `lnk_addr_stb_n` and offsets 4 to 7 drive `lnk_data_stb_n`. The two strobes are never low together.
- R7: A link access completes only after hold has returned low following the strobe release. No new strobe begins while the synchronized hold is high.
- R8: If hold does not respond within `TIMEOUT_CYCLES` clocks, the cycle is aborted and status bit 0 is set. A timed-out read returns 8'hFF. A strobe is never low for more than `TIMEOUT_CYCLES` cycles.
- R9: A rising edge on `lnk_irq_n` sets status bit 1, and a falling edge does not. `irq_o` equals pending AND control bit 0.
- R10: A status read returns the flags as they were before the read, then clears bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU access request valid |
| req_ready | output | 1 | Access granted/completed this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 3 | Register offset 0..7 |
| req_wdata | input | 8 | Write byte |
| req_rdata | output | 8 | Read byte, valid while req_ready is high |
| irq_o | output | 1 | Interrupt request to the CPU |
| lnk_ad_out | output | 8 | Address/data byte driven to the link |
| lnk_ad_oe | output | 1 | Output enable for lnk_ad_out |
| lnk_ad_in | input | 8 | Address/data byte sampled from the link |
| lnk_wr_n | output | 1 | Low during write cycles |
| lnk_addr_stb_n | output | 1 | Active-low address strobe |
| lnk_data_stb_n | output | 1 | Active-low data strobe |
| lnk_hold_n | input | 1 | Peripheral handshake, low when idle |
| lnk_irq_n | input | 1 | Peripheral interrupt, acts on its rising edge |

## Verification
Local register accesses are due in the cycle they are presented. The bench samples `req_ready` 1 ns after the falling edge on which it drove the request and requires a zero-cycle wait. In a write cycle the output enable is due exactly one cycle after `lnk_wr_n` falls, and the strobe one cycle after that. A falling-edge monitor timestamps these transitions and checks both gaps of one cycle. An interrupt edge passes two synchronizer stages and one flag register, so the pending flag is due three rising edges after the line changes. The bench reads it four falling edges later, and it confirms a timeout only after the access has waited at least `TIMEOUT_CYCLES` cycles.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    L_IDLE,
    L_SETUP,
    L_DRIVE,
    L_STROBE,
    L_RELEASE,
    L_DONE
  } link_state_e;

  // register offsets (the link offsets start at OFF_ADDR)
  localparam int OFF_HOLD = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_CTRL = 2;
  localparam int OFF_ADDR = 3;

  // status bit positions
  localparam int ST_TMO  = 0;
  localparam int ST_IRQ  = 1;
  localparam int ST_HOLD = 2;
  localparam int ST_LINE = 3;

  // control bit positions
  localparam int CTRL_IRQ_EN = 0;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= {STAGES{RST_VAL}};
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pbus_link_fsm.sv
module pbus_link_fsm
  import pbus_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_addr,
  input  logic              start_wr,
  input  logic [BYTE_W-1:0] start_byte,
  input  logic              hold_s,
  input  logic [BYTE_W-1:0] ad_in,
  output logic              idle,
  output logic              done,
  output logic              timed_out,
  output logic [BYTE_W-1:0] xfer_byte,
  output logic [BYTE_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              wr_n,
  output logic              astb_n,
  output logic              dstb_n
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  link_state_e       st_q;
  logic              kind_addr_q;
  logic              kind_wr_q;
  logic              abort_q;
  logic [BYTE_W-1:0] wbyte_q;
  logic [BYTE_W-1:0] rbyte_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              expired;

  assign expired = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= L_IDLE;
      kind_addr_q <= 1'b0;
      kind_wr_q   <= 1'b0;
      abort_q     <= 1'b0;
      wbyte_q     <= '0;
      rbyte_q     <= '0;
      cnt_q       <= '0;
    end else begin
      unique case (st_q)
        L_IDLE: begin
          abort_q <= 1'b0;
          // a new cycle must wait for the previous handshake to settle
          if (start && !hold_s) begin
            kind_addr_q <= start_addr;
            kind_wr_q   <= start_wr;
            wbyte_q     <= start_byte;
            st_q        <= L_SETUP;
          end
        end
        L_SETUP: begin
          cnt_q <= '0;
          st_q  <= kind_wr_q ? L_DRIVE : L_STROBE;
        end
        L_DRIVE: begin
          st_q <= L_STROBE;
        end
        L_STROBE: begin
          if (hold_s) begin
            if (!kind_wr_q) rbyte_q <= ad_in;
            cnt_q <= '0;
            st_q  <= L_RELEASE;
          end else if (expired) begin
            if (!kind_wr_q) rbyte_q <= '1;
            abort_q <= 1'b1;
            st_q    <= L_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        L_RELEASE: begin
          if (!hold_s) begin
            st_q <= L_DONE;
          end else if (expired) begin
            if (!kind_wr_q) rbyte_q <= '1;
            abort_q <= 1'b1;
            st_q    <= L_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        L_DONE: begin
          st_q <= L_IDLE;
        end
        default: st_q <= L_IDLE;
      endcase
    end
  end

  logic in_cycle;
  logic strobing;
  assign in_cycle = (st_q == L_SETUP) || (st_q == L_DRIVE) ||
                    (st_q == L_STROBE) || (st_q == L_RELEASE);
  assign strobing = (st_q == L_STROBE);

  assign idle      = (st_q == L_IDLE);
  assign done      = (st_q == L_DONE);
  assign timed_out = done && abort_q;
  assign xfer_byte = kind_wr_q ? wbyte_q : rbyte_q;
  assign ad_out    = wbyte_q;
  assign wr_n      = !(in_cycle && kind_wr_q);
  assign ad_oe     = kind_wr_q && ((st_q == L_DRIVE) || (st_q == L_STROBE) ||
                                   (st_q == L_RELEASE));
  assign astb_n    = !(strobing && kind_addr_q);
  assign dstb_n    = !(strobing && !kind_addr_q);

endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
  import pbus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OFFS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_fire,
  input  logic              acc_write,
  input  logic [OFFS_W-1:0] acc_offset,
  input  logic [BYTE_W-1:0] acc_wdata,
  input  logic              link_done,
  input  logic              link_timeout,
  input  logic [BYTE_W-1:0] link_byte,
  input  logic              hold_s,
  input  logic              line_s,
  output logic [BYTE_W-1:0] local_rdata,
  output logic              irq_o
);

  logic [BYTE_W-1:0] hold_reg_q;
  logic [BYTE_W-1:0] ctrl_q;
  logic              tmo_q;
  logic              pend_q;
  logic              line_d_q;
  logic [BYTE_W-1:0] stat;
  logic              rise;
  logic              stat_rd;

  assign rise    = line_s && !line_d_q;
  assign stat_rd = acc_fire && !acc_write && (acc_offset == OFFS_W'(OFF_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_reg_q <= '0;
      ctrl_q     <= '0;
      tmo_q      <= 1'b0;
      pend_q     <= 1'b0;
      line_d_q   <= 1'b1;
    end else begin
      line_d_q <= line_s;
      if (acc_fire && acc_write) begin
        if (acc_offset == OFFS_W'(OFF_HOLD)) hold_reg_q <= acc_wdata;
        if (acc_offset == OFFS_W'(OFF_CTRL)) ctrl_q     <= acc_wdata;
      end
      if (link_done && !link_timeout) hold_reg_q <= link_byte;
      // set wins over the read-to-clear
      if (link_timeout)  tmo_q <= 1'b1;
      else if (stat_rd)  tmo_q <= 1'b0;
      if (rise)          pend_q <= 1'b1;
      else if (stat_rd)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_TMO]  = tmo_q;
    stat[ST_IRQ]  = pend_q;
    stat[ST_HOLD] = hold_s;
    stat[ST_LINE] = line_s;
  end

  always_comb begin
    unique case (acc_offset)
      OFFS_W'(OFF_HOLD): local_rdata = hold_reg_q;
      OFFS_W'(OFF_STAT): local_rdata = stat;
      OFFS_W'(OFF_CTRL): local_rdata = ctrl_q;
      default:           local_rdata = '0;
    endcase
  end

  assign irq_o = pend_q && ctrl_q[CTRL_IRQ_EN];

endmodule

// File: rtl/pbus_host.sv
module pbus_host
  import pbus_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int OFFS_W         = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFFS_W-1:0] req_offset,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic [BYTE_W-1:0] req_rdata,
  output logic              irq_o,
  output logic [BYTE_W-1:0] lnk_ad_out,
  output logic              lnk_ad_oe,
  input  logic [BYTE_W-1:0] lnk_ad_in,
  output logic              lnk_wr_n,
  output logic              lnk_addr_stb_n,
  output logic              lnk_data_stb_n,
  input  logic              lnk_hold_n,
  input  logic              lnk_irq_n
);

  logic              hold_s;
  logic              line_s;
  logic              is_link;
  logic              link_idle;
  logic              link_done;
  logic              link_tmo;
  logic [BYTE_W-1:0] link_byte;
  logic [BYTE_W-1:0] local_rdata;
  logic              fire;

  pbus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hold_sync (
    .clk(clk), .rst_n(rst_n), .d(lnk_hold_n), .q(hold_s)
  );

  pbus_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d(lnk_irq_n), .q(line_s)
  );

  assign is_link = (req_offset >= OFFS_W'(OFF_ADDR));

  pbus_link_fsm #(.BYTE_W(BYTE_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_valid && is_link),
    .start_addr (req_offset == OFFS_W'(OFF_ADDR)),
    .start_wr   (req_write),
    .start_byte (req_wdata),
    .hold_s     (hold_s),
    .ad_in      (lnk_ad_in),
    .idle       (link_idle),
    .done       (link_done),
    .timed_out  (link_tmo),
    .xfer_byte  (link_byte),
    .ad_out     (lnk_ad_out),
    .ad_oe      (lnk_ad_oe),
    .wr_n       (lnk_wr_n),
    .astb_n     (lnk_addr_stb_n),
    .dstb_n     (lnk_data_stb_n)
  );

  assign req_ready = is_link ? link_done : link_idle;
  assign fire      = req_valid && req_ready;
  assign req_rdata = is_link ? link_byte : local_rdata;

  pbus_regfile #(.BYTE_W(BYTE_W), .OFFS_W(OFFS_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_fire     (fire),
    .acc_write    (req_write),
    .acc_offset   (req_offset),
    .acc_wdata    (req_wdata),
    .link_done    (link_done),
    .link_timeout (link_tmo),
    .link_byte    (link_byte),
    .hold_s       (hold_s),
    .line_s       (line_s),
    .local_rdata  (local_rdata),
    .irq_o        (irq_o)
  );

endmodule

// File: rtl/pbus_host_checker.sv
module pbus_host_checker #(
  parameter int TIMEOUT_CYCLES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic lnk_wr_n,
  input logic lnk_ad_oe,
  input logic lnk_addr_stb_n,
  input logic lnk_data_stb_n
);

  logic strobe_low;
  int   low_run;

  assign strobe_low = !lnk_addr_stb_n || !lnk_data_stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= 0;
    else if (strobe_low) low_run <= (low_run < TIMEOUT_CYCLES + 4) ? low_run + 1 : low_run;
    else                 low_run <= 0;
  end

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lnk_addr_stb_n && !lnk_data_stb_n));

  assert_oe_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ad_oe |-> !lnk_wr_n);

  assert_read_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low && lnk_wr_n) |-> !lnk_ad_oe);

  assert_write_holds_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low && !lnk_wr_n) |-> lnk_ad_oe);

  assert_dir_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> $stable(lnk_wr_n));

  assert_strobe_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> (low_run < TIMEOUT_CYCLES));

endmodule

bind pbus_host pbus_host_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .lnk_wr_n       (lnk_wr_n),
  .lnk_ad_oe      (lnk_ad_oe),
  .lnk_addr_stb_n (lnk_addr_stb_n),
  .lnk_data_stb_n (lnk_data_stb_n)
);

// File: tb/pbus_host_test.sv
`timescale 1ns/1ps
module pbus_host_test;

  localparam int TMO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [2:0] req_offset = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] req_rdata;
  logic       irq_o;
  logic [7:0] lnk_ad_out;
  logic       lnk_ad_oe;
  logic [7:0] lnk_ad_in = '0;
  logic       lnk_wr_n;
  logic       lnk_addr_stb_n;
  logic       lnk_data_stb_n;
  logic       lnk_hold_n = 1'b0;
  logic       lnk_irq_n = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pbus_host #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .irq_o(irq_o), .lnk_ad_out(lnk_ad_out),
    .lnk_ad_oe(lnk_ad_oe), .lnk_ad_in(lnk_ad_in), .lnk_wr_n(lnk_wr_n),
    .lnk_addr_stb_n(lnk_addr_stb_n), .lnk_data_stb_n(lnk_data_stb_n),
    .lnk_hold_n(lnk_hold_n), .lnk_irq_n(lnk_irq_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- peripheral model ----------------
  int         p_mode = 1;     // 0 silent, 1 normal, 2 never lowers hold
  int         p_up = 2;
  int         p_dn = 1;
  logic [7:0] p_addr = 8'h00;
  logic [7:0] p_data = 8'h00;
  logic [7:0] p_rdbyte = 8'h00;
  bit         p_last_was_addr = 0;
  bit         p_oe_at_rise = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (p_mode != 0 && (!lnk_addr_stb_n || !lnk_data_stb_n) && !lnk_hold_n) begin
        automatic bit is_a = !lnk_addr_stb_n;
        automatic bit is_w = !lnk_wr_n;
        repeat (p_up) @(negedge clk);
        if (!is_w) lnk_ad_in = is_a ? p_addr : p_rdbyte;
        lnk_hold_n = 1'b1;
        wait (lnk_addr_stb_n && lnk_data_stb_n);
        if (is_w) begin
          p_oe_at_rise = lnk_ad_oe;
          p_last_was_addr = is_a;
          if (is_a) p_addr = lnk_ad_out;
          else      p_data = lnk_ad_out;
        end
        if (p_mode != 2) begin
          @(negedge clk);
          repeat (p_dn) @(negedge clk);
          lnk_hold_n = 1'b0;
        end
      end
    end
  end

  // ---------------- edge timestamp monitor ----------------
  int cyc_n = 0, t_wr = 0, t_oe = 0, t_stb = 0, rd_oe_bad = 0;
  logic prev_wr_n = 1'b1, prev_oe = 1'b0, prev_stb = 1'b1;

  always @(negedge clk) begin
    cyc_n++;
    if (prev_wr_n && !lnk_wr_n) t_wr = cyc_n;
    if (!prev_oe && lnk_ad_oe) t_oe = cyc_n;
    if (prev_stb && !(lnk_addr_stb_n && lnk_data_stb_n)) t_stb = cyc_n;
    if (!(lnk_addr_stb_n && lnk_data_stb_n) && lnk_wr_n && lnk_ad_oe) rd_oe_bad++;
    prev_wr_n = lnk_wr_n;
    prev_oe   = lnk_ad_oe;
    prev_stb  = lnk_addr_stb_n && lnk_data_stb_n;
  end

  // ---------------- CPU access ----------------
  task automatic access(input bit w, input int off, input logic [7:0] wd,
                        output logic [7:0] rd, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_offset = off[2:0]; req_wdata = wd;
    cyc = 0; rd = 8'h00;
    forever begin
      #1;
      if (req_ready) begin rd = req_rdata; break; end
      @(negedge clk);
      cyc++;
      if (cyc > 3000) begin
        chk(0, "access hung", 32'(cyc), 32'd0);
        break;
      end
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] rd; int c;
    chk(lnk_addr_stb_n && lnk_data_stb_n, "R1 strobes idle", {lnk_addr_stb_n, lnk_data_stb_n}, 32'h3);
    chk(lnk_wr_n == 1'b1 && lnk_ad_oe == 1'b0, "R1 wr_n/oe idle", {lnk_wr_n, lnk_ad_oe}, 32'h2);
    chk(irq_o == 1'b0, "R1 irq low", irq_o, 0);
    access(0, 0, 8'h00, rd, c); chk(rd == 8'h00, "R1 holding reg", rd, 8'h00);
    access(0, 2, 8'h00, rd, c); chk(rd == 8'h00, "R1 control reg", rd, 8'h00);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h08, "R3 status after reset", rd, 8'h08);
  endtask

  task automatic t_local();
    logic [7:0] rd; int c;
    access(1, 2, 8'hA5, rd, c); chk(c == 0, "R2 control write zero wait", c, 0);
    access(0, 2, 8'h00, rd, c); chk(rd == 8'hA5 && c == 0, "R2 control readback", rd, 8'hA5);
    access(1, 0, 8'h3C, rd, c);
    access(0, 0, 8'h00, rd, c); chk(rd == 8'h3C, "R2 holding readback", rd, 8'h3C);
  endtask

  task automatic t_status_ro();
    logic [7:0] rd; int c;
    access(1, 1, 8'hFF, rd, c);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h08, "R3 status ignores writes", rd, 8'h08);
  endtask

  task automatic t_addr_write();
    logic [7:0] rd; int c;
    access(1, 3, 8'h12, rd, c);
    chk(p_addr == 8'h12 && p_last_was_addr, "R6 address strobe carries address", p_addr, 8'h12);
    chk(t_oe - t_wr == 1, "R4 oe one cycle after wr_n", 32'(t_oe - t_wr), 1);
    chk(t_stb - t_oe == 1, "R4 strobe one cycle after oe", 32'(t_stb - t_oe), 1);
    chk(p_oe_at_rise, "R4 bus driven at strobe release", p_oe_at_rise, 1);
    chk(lnk_hold_n == 1'b0, "R7 done only after hold low", lnk_hold_n, 0);
    access(0, 0, 8'h00, rd, c); chk(rd == 8'h12, "R2 holding reg tracks link byte", rd, 8'h12);
  endtask

  task automatic t_data_writes();
    logic [7:0] rd; int c;
    for (int off = 4; off < 8; off++) begin
      access(1, off, 8'(8'h40 + off), rd, c);
      chk(p_data == 8'(8'h40 + off) && !p_last_was_addr, "R6 data strobe for offset", p_data, 8'(8'h40 + off));
    end
    chk(p_addr == 8'h12, "R6 data cycles leave address", p_addr, 8'h12);
  endtask

  task automatic t_reads();
    logic [7:0] rd; int c;
    access(0, 3, 8'h00, rd, c); chk(rd == 8'h12, "R5 address read", rd, 8'h12);
    p_rdbyte = 8'hC3;
    access(0, 6, 8'h00, rd, c); chk(rd == 8'hC3, "R5 data read", rd, 8'hC3);
    chk(rd_oe_bad == 0, "R5 bus floated on read strobe", rd_oe_bad, 0);
    access(0, 0, 8'h00, rd, c); chk(rd == 8'hC3, "R2 holding after read", rd, 8'hC3);
  endtask

  task automatic t_timeout();
    logic [7:0] rd; int c;
    p_mode = 0;
    access(1, 4, 8'h99, rd, c); chk(c >= TMO, "R8 aborts after timeout", c, TMO);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h09, "R8 timeout flag set", rd, 8'h09);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h08, "R10 status read clears", rd, 8'h08);
    access(0, 5, 8'h00, rd, c); chk(rd == 8'hFF, "R8 timed-out read value", rd, 8'hFF);
    access(0, 0, 8'h00, rd, c); chk(rd == 8'hC3, "R8 holding unchanged on abort", rd, 8'hC3);
    access(0, 1, 8'h00, rd, c);
    p_mode = 1;
  endtask

  task automatic t_hold_off();
    logic [7:0] rd; int c; int bad = 0;
    p_mode = 2;
    access(1, 4, 8'h55, rd, c);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h0D, "R7 stuck hold times out in release", rd, 8'h0D);
    p_rdbyte = 8'h77;
    fork
      access(0, 7, 8'h00, rd, c);
      begin
        repeat (10) begin
          @(negedge clk); #2;
          if (!lnk_data_stb_n || req_ready) bad++;
        end
        p_mode = 1;
        lnk_hold_n = 1'b0;
      end
    join
    chk(bad == 0, "R7 no strobe while hold high", bad, 0);
    chk(rd == 8'h77, "R7 held read completes", rd, 8'h77);
  endtask

  task automatic t_irq();
    logic [7:0] rd; int c;
    @(negedge clk); lnk_irq_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(irq_o == 1'b0, "R9 falling edge ignored", irq_o, 0);
    lnk_irq_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq_o == 1'b1, "R9 rising edge raises irq", irq_o, 1);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h0A, "R9 pending in status", rd, 8'h0A);
    #2 chk(irq_o == 1'b0, "R10 irq cleared by status read", irq_o, 0);
    access(1, 2, 8'h00, rd, c);
    @(negedge clk); lnk_irq_n = 1'b0;
    repeat (4) @(negedge clk); lnk_irq_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq_o == 1'b0, "R9 irq masked by control", irq_o, 0);
    access(0, 1, 8'h00, rd, c); chk(rd == 8'h0A, "R9 pending while masked", rd, 8'h0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_local();
    t_status_ro();
    t_addr_write();
    t_data_writes();
    t_reads();
    t_timeout();
    t_hold_off();
    t_irq();
    summary();
  end

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

endmodule